// File: doc/BRIEF.md
# TDM Four-Octet Channel Slave

This block is the slave end of a four-wire time-division bus: a frame sync that runs at 8 kHz, a data clock, one downstream data line and one upstream data line. The data clock runs at twice the bit rate, so each bit cell lasts two clock periods. A rate select picks one of two bus formats. In the slow format the clock runs at 512 kHz and a frame holds one 32-bit channel. In the fast format the clock runs at 4096 kHz and a frame holds eight channels. In the fast format a slot-select input names the channel the block owns.

Within its channel the block receives four octets in this order: first voice, second voice, monitor, control. The control octet carries a six-bit command field followed by the two monitor handshake bits. The received fields go to output pins. In the same bit positions upstream, the block sends its two local voice octets, a monitor octet and a control octet. The control octet carries a filtered indication field taken from six indication inputs. The block drives the upstream line only during its own 32 bit cells. Outside them the line is released. Two rules shape what goes upstream. A monitor byte is repeated over at least two frames. A change on the indication inputs can be made to persist for a programmable number of milliseconds before it is reported.

Top module: `tdm_chan_slave`

## Requirements
- R1: While `rst` is high and after it falls, `du_en` is 0, `du_dat` is 1, all receive outputs are 0 and `rx_strobe` is 0, until the first frame arrives.
- R2: A rising edge on `fsync` sampled by `clk` marks clock index 0 of a frame. Bit cell b spans clock indices 2b and 2b+1. Downstream bits are sampled at the edge of index 2b+1, and every octet is sent most significant bit first.
- R3: With `rate_hi` = 0 a frame has 64 clocks and the block owns bits 0 to 31. `slot_sel` has no effect in this mode.
- R4: With `rate_hi` = 1 a frame has 512 clocks and the block owns bits 32*s to 32*s+31, where s = `slot_sel`. Downstream bits outside this range do not change any output.
- R5: Downstream octets arrive in the order first voice (`v1_rx`), second voice (`v2_rx`), monitor (`mon_rx`), control. Control bits 7:2 go to `cmd_rx`, bit 1 to `mr_rx` and bit 0 to `mx_rx`.
- R6: Each voice and monitor output updates when its own octet completes. The control fields update when the last bit of the channel is taken, together with a one-cycle `rx_strobe`. So each frame gives exactly one strobe.
- R7: `du_en` is high at the sampling edge of every owned bit cell and low at every other edge. While `du_en` is low, `du_dat` is 1.
- R8: The upstream word is sent MSB first as `v1_tx`, `v2_tx`, the held monitor byte, then {indication field, `mr_up`, `mx_up`}. The word is captured at the frame's sync edge.
- R9: With `upd_int` = 0, the indication field sent in a frame equals `ind_in` as sampled at that frame's sync edge.
- R10: With `upd_int` = n (1..15), a new indication value is sent only in the frame where it has been sampled in 8n consecutive frames (n ms). A shorter excursion leaves the field unchanged.
- R11: Each upstream monitor byte goes out in at least two consecutive frames. A differing `mon_tx` is taken at the next sync edge once the current byte has been sent twice. After reset the first `mon_tx` is taken at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus data clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | 8 kHz frame sync |
| rate_hi | input | 1 | 1 = eight channels per frame, 0 = one |
| slot_sel | input | 3 | Owned channel in the fast format |
| dd | input | 1 | Downstream serial data |
| du_dat | output | 1 | Upstream serial data |
| du_en | output | 1 | Upstream driver enable (pad released when 0) |
| v1_rx | output | 8 | Received first voice octet |
| v2_rx | output | 8 | Received second voice octet |
| mon_rx | output | 8 | Received monitor octet |
| cmd_rx | output | 6 | Received command field |
| mr_rx | output | 1 | Received MR handshake bit |
| mx_rx | output | 1 | Received MX handshake bit |
| rx_strobe | output | 1 | One-cycle pulse when the control fields update |
| v1_tx | input | 8 | First voice octet to send |
| v2_tx | input | 8 | Second voice octet to send |
| mon_tx | input | 8 | Monitor byte to send |
| mr_up | input | 1 | MR bit to send |
| mx_up | input | 1 | MX bit to send |
| ind_in | input | 6 | Indication inputs |
| upd_int | input | 4 | Persistence interval in ms, 0 disables |

## Verification
Some properties are checked on every cycle by the assertions. The sample strobe never fires on two clocks in a row, which fixes the two-clock bit cell. The command outputs move only with the receive strobe. The reported indication field changes only at a sync edge. The monitor byte is never replaced before it has gone out twice. Other behaviour only the bench scenarios can show. This covers slot placement at both rates, with foreign data in the other channels. It also covers the exact serial order of each octet, the frame on which a persistent indication first appears for 1 ms and 2 ms intervals, and the rejection of a short glitch.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int OCTETS    = 4;
  localparam int SLOT_BITS = 8 * OCTETS;
  localparam int CI_W      = 6;
  localparam logic [7:0] MON_IDLE = 8'hFF;

  typedef enum logic [1:0] {
    OCT_V1  = 2'd0,
    OCT_V2  = 2'd1,
    OCT_MON = 2'd2,
    OCT_CTL = 2'd3
  } octet_e;
endpackage

// File: rtl/tdm_slot_timebase.sv
module tdm_slot_timebase #(
  parameter  int MAX_CH    = 8,
  parameter  int SLOT_BITS = 32,
  localparam int CHW       = $clog2(MAX_CH),
  localparam int SBW       = $clog2(SLOT_BITS),
  localparam int LEN_LO    = 2 * SLOT_BITS,
  localparam int LEN_HI    = 2 * SLOT_BITS * MAX_CH,
  localparam int CW        = $clog2(LEN_HI + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fsync,
  input  logic           rate_hi,
  input  logic [CHW-1:0] slot_sel,
  output logic           fs_rise,
  output logic           rx_take,
  output logic [SBW-1:0] rx_bit,
  output logic           tx_own,
  output logic [SBW-1:0] tx_bit
);
  logic          fs_q;
  logic [CW-1:0] cc, cur, nxt, len;

  function automatic logic own_f(input logic [CW-1:0] i, input logic hi,
                                 input logic [CHW-1:0] sel, input logic [CW-1:0] l);
    return (i < l) && (!hi || (i[SBW+CHW:SBW+1] == sel));
  endfunction

  assign fs_rise = fsync & ~fs_q;
  assign cur     = fs_rise ? '0 : cc;
  assign nxt     = cur + 1'b1;
  assign len     = rate_hi ? CW'(LEN_HI) : CW'(LEN_LO);

  assign rx_take = own_f(cur, rate_hi, slot_sel, len) & cur[0];
  assign rx_bit  = cur[SBW:1];
  assign tx_own  = own_f(nxt, rate_hi, slot_sel, len);
  assign tx_bit  = nxt[SBW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q <= 1'b0;
      cc   <= CW'(LEN_HI);
    end else begin
      fs_q <= fsync;
      cc   <= (cur == CW'(LEN_HI)) ? cur : nxt;
    end
  end

  // R2: one sample per two-clock bit cell
  p_one_sample_per_cell_r2: assert property (@(posedge clk) disable iff (rst)
    rx_take |=> !rx_take);
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_slot_pkg::*;
#(
  parameter  int SLOT_BITS = 32,
  localparam int SBW       = $clog2(SLOT_BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [SBW-1:0]  bit_idx,
  input  logic            dd,
  output logic [7:0]      v1_rx,
  output logic [7:0]      v2_rx,
  output logic [7:0]      mon_rx,
  output logic [CI_W-1:0] cmd_rx,
  output logic            mr_rx,
  output logic            mx_rx,
  output logic            strobe
);
  logic [6:0] sreg;
  logic [7:0] byte_in;
  logic       byte_end;
  octet_e     oct;

  assign byte_in  = {sreg, dd};
  assign byte_end = take && (bit_idx[2:0] == 3'b111);
  assign oct      = octet_e'(bit_idx[SBW-1:3]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      v1_rx  <= '0;
      v2_rx  <= '0;
      mon_rx <= '0;
      cmd_rx <= '0;
      mr_rx  <= 1'b0;
      mx_rx  <= 1'b0;
      strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (take) sreg <= byte_in[6:0];
      if (byte_end) begin
        case (oct)
          OCT_V1:  v1_rx  <= byte_in;
          OCT_V2:  v2_rx  <= byte_in;
          OCT_MON: mon_rx <= byte_in;
          OCT_CTL: begin
            cmd_rx <= byte_in[7:2];
            mr_rx  <= byte_in[1];
            mx_rx  <= byte_in[0];
            strobe <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: command field moves only together with the strobe
  p_cmd_with_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_rx) |-> strobe);
endmodule

// File: rtl/tdm_ci_filter.sv
module tdm_ci_filter #(
  parameter  int CI_W  = 6,
  parameter  int INT_W = 4,
  parameter  int FPMS  = 8,
  localparam int LIM   = FPMS * ((1 << INT_W) - 1),
  localparam int SW    = $clog2(LIM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample,
  input  logic [CI_W-1:0]  ind,
  input  logic [INT_W-1:0] interval,
  output logic [CI_W-1:0]  ci_nxt,
  output logic [CI_W-1:0]  ci_q
);
  logic [CI_W-1:0] cand;
  logic [SW-1:0]   seen, seen_nxt, need;

  assign need     = SW'(interval) * SW'(FPMS);
  assign seen_nxt = (ind != cand)       ? SW'(1) :
                    (seen == SW'(LIM))  ? seen   : seen + 1'b1;

  always_comb begin
    ci_nxt = ci_q;
    if (sample) begin
      if (interval == '0)         ci_nxt = ind;
      else if (seen_nxt >= need)  ci_nxt = ind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand <= '0;
      seen <= SW'(LIM);
      ci_q <= '0;
    end else if (sample) begin
      cand <= ind;
      seen <= seen_nxt;
      ci_q <= ci_nxt;
    end
  end

  // R10: the reported field changes only at a frame sync
  p_ci_at_sync_only_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(ci_q) |-> $past(sample));
endmodule

// File: rtl/tdm_chan_slave.sv
module tdm_chan_slave
  import tdm_slot_pkg::*;
#(
  parameter  int MAX_CH = 8,
  parameter  int INT_W  = 4,
  parameter  int FPMS   = 8,
  localparam int CHW    = $clog2(MAX_CH),
  localparam int SBW    = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  logic             rate_hi,
  input  logic [CHW-1:0]   slot_sel,
  input  logic             dd,
  output logic             du_dat,
  output logic             du_en,
  output logic [7:0]       v1_rx,
  output logic [7:0]       v2_rx,
  output logic [7:0]       mon_rx,
  output logic [CI_W-1:0]  cmd_rx,
  output logic             mr_rx,
  output logic             mx_rx,
  output logic             rx_strobe,
  input  logic [7:0]       v1_tx,
  input  logic [7:0]       v2_tx,
  input  logic [7:0]       mon_tx,
  input  logic             mr_up,
  input  logic             mx_up,
  input  logic [CI_W-1:0]  ind_in,
  input  logic [INT_W-1:0] upd_int
);
  logic                 fs_rise, rx_take, tx_own;
  logic [SBW-1:0]       rx_bit, tx_bit;
  logic [CI_W-1:0]      ci_nxt, ci_q;
  logic [7:0]           mon_cur, mon_nxt;
  logic [1:0]           mon_sent;
  logic                 mon_take;
  logic [SLOT_BITS-1:0] tx_word, word_new, word_src;

  tdm_slot_timebase #(.MAX_CH(MAX_CH), .SLOT_BITS(SLOT_BITS)) u_tb (
    .clk(clk), .rst(rst), .fsync(fsync), .rate_hi(rate_hi), .slot_sel(slot_sel),
    .fs_rise(fs_rise), .rx_take(rx_take), .rx_bit(rx_bit),
    .tx_own(tx_own), .tx_bit(tx_bit));

  tdm_slot_rx #(.SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(clk), .rst(rst), .take(rx_take), .bit_idx(rx_bit), .dd(dd),
    .v1_rx(v1_rx), .v2_rx(v2_rx), .mon_rx(mon_rx), .cmd_rx(cmd_rx),
    .mr_rx(mr_rx), .mx_rx(mx_rx), .strobe(rx_strobe));

  tdm_ci_filter #(.CI_W(CI_W), .INT_W(INT_W), .FPMS(FPMS)) u_ci (
    .clk(clk), .rst(rst), .sample(fs_rise), .ind(ind_in), .interval(upd_int),
    .ci_nxt(ci_nxt), .ci_q(ci_q));

  // monitor byte repetition
  assign mon_take = fs_rise && (mon_sent == 2'd2) && (mon_tx != mon_cur);
  assign mon_nxt  = mon_take ? mon_tx : mon_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_cur  <= MON_IDLE;
      mon_sent <= 2'd2;
    end else if (fs_rise) begin
      mon_cur  <= mon_nxt;
      mon_sent <= mon_take ? 2'd1 : ((mon_sent == 2'd2) ? 2'd2 : mon_sent + 2'd1);
    end
  end

  // upstream serialiser
  assign word_new = {v1_tx, v2_tx, mon_nxt, ci_nxt, mr_up, mx_up};
  assign word_src = fs_rise ? word_new : tx_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word <= '1;
      du_en   <= 1'b0;
      du_dat  <= 1'b1;
    end else begin
      if (fs_rise) tx_word <= word_new;
      du_en  <= tx_own;
      du_dat <= tx_own ? word_src[SBW'(SLOT_BITS - 1) - tx_bit] : 1'b1;
    end
  end

  // R11: a monitor byte is replaced only after two sends
  p_mon_twice_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(mon_cur) |-> ($past(mon_sent) == 2'd2));
endmodule

// File: tb/tdm_chan_slave_tb.sv
module tdm_chan_slave_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsync = 1'b0, rate_hi = 1'b0, dd = 1'b1;
  logic [2:0] slot_sel = '0;
  logic du_dat, du_en, mr_rx, mx_rx, rx_strobe;
  logic [7:0] v1_rx, v2_rx, mon_rx;
  logic [5:0] cmd_rx;
  logic [7:0] v1_tx = '0, v2_tx = '0, mon_tx = 8'h96;
  logic mr_up = 1'b1, mx_up = 1'b0;
  logic [5:0] ind_in = '0;
  logic [3:0] upd_int = '0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tdm_chan_slave u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .rate_hi(rate_hi), .slot_sel(slot_sel),
    .dd(dd), .du_dat(du_dat), .du_en(du_en), .v1_rx(v1_rx), .v2_rx(v2_rx),
    .mon_rx(mon_rx), .cmd_rx(cmd_rx), .mr_rx(mr_rx), .mx_rx(mx_rx),
    .rx_strobe(rx_strobe), .v1_tx(v1_tx), .v2_tx(v2_tx), .mon_tx(mon_tx),
    .mr_up(mr_up), .mx_up(mx_up), .ind_in(ind_in), .upd_int(upd_int));

  // {rate, slot, downstream word, v1_tx, v2_tx, ind}
  localparam logic [57:0] VEC [6] = '{
    {1'b0, 3'd0, 32'hA53CE79E, 8'h11, 8'h22, 6'h15},
    {1'b0, 3'd5, 32'h0180FF03, 8'hC3, 8'h3C, 6'h2A},
    {1'b1, 3'd0, 32'h123456FD, 8'h55, 8'hAA, 6'h3F},
    {1'b1, 3'd3, 32'hDEADBEEF, 8'h0F, 8'hF0, 6'h00},
    {1'b1, 3'd7, 32'h7E814252, 8'h99, 8'h66, 6'h21},
    {1'b0, 3'd2, 32'hC0010FAA, 8'h4B, 8'hB4, 6'h11}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic rate, input logic [2:0] slot, input logic [31:0] dn,
                           output logic [31:0] up, output int en_bad, output int strobes);
    int len;
    len = rate ? 512 : 64;
    up = '1; en_bad = 0; strobes = 0;
    for (int k = 0; k < len; k++) begin
      int b;
      logic own;
      @(negedge clk);
      b   = k >> 1;
      own = rate ? (3'(b >> 5) == slot) : 1'b1;
      if (k >= 1 && du_en !== own) en_bad++;
      if (own && k[0]) up[31 - (b % 32)] = du_dat;
      if (k >= 1 && !du_en && du_dat !== 1'b1) en_bad++;
      if (rx_strobe) strobes++;
      if (k == 0) begin rate_hi = rate; slot_sel = slot; end
      fsync = (k < 4);
      dd = own ? dn[31 - (b % 32)] : ~dn[31 - (b % 32)];
    end
    @(negedge clk);
    if (rx_strobe) strobes++;
    if (du_en !== 1'b0) en_bad++;
    fsync = 1'b0;
    dd = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] up;
    int en_bad, strobes;
    repeat (4) @(negedge clk);
    chk("R1 du_en in reset", {31'd0, du_en}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle after reset", {8'd0, v1_rx, cmd_rx, mr_rx, mx_rx, rx_strobe, du_en, du_dat, 7'd0},
        {8'd0, 8'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'd0});

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 6; i++) begin
      logic r;
      logic [2:0] s;
      logic [31:0] dn;
      r = VEC[i][57]; s = VEC[i][56:54]; dn = VEC[i][53:22];
      v1_tx = VEC[i][21:14]; v2_tx = VEC[i][13:6]; ind_in = VEC[i][5:0];
      run_frame(r, s, dn, up, en_bad, strobes);
      chk(r ? "R4 R5 R2 downstream fields" : "R3 R5 R2 downstream fields",
          {v1_rx, v2_rx, mon_rx, cmd_rx, mr_rx, mx_rx}, dn);
      chk("R6 one strobe per frame", 32'(strobes), 32'd1);
      chk("R7 upstream enable window", 32'(en_bad), 32'd0);
      chk("R8 upstream word", {up[31:8], 6'd0, up[1:0]},
          {VEC[i][21:14], VEC[i][13:6], 8'h96, 6'd0, 2'b10});
      chk("R9 immediate indication", {26'd0, up[7:2]}, {26'd0, VEC[i][5:0]});
    end

    // R10: 1 ms persistence, value appears on the 8th frame
    upd_int = 4'd1;
    ind_in = 6'h2D;
    for (int f = 1; f <= 8; f++) begin
      run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
      if (f == 7) chk("R10 held before 8 frames", {26'd0, up[7:2]}, 32'h11);
      if (f == 8) chk("R10 reported after 8 frames", {26'd0, up[7:2]}, 32'h2D);
    end
    // R10: a three-frame glitch is not reported
    ind_in = 6'h07;
    for (int f = 1; f <= 3; f++) begin
      run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
      chk("R10 glitch rejected", {26'd0, up[7:2]}, 32'h2D);
    end
    ind_in = 6'h2D;
    run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
    chk("R10 back to stable value", {26'd0, up[7:2]}, 32'h2D);
    // R10: 2 ms persistence, sixteen frames
    upd_int = 4'd2;
    ind_in = 6'h30;
    for (int f = 1; f <= 16; f++) begin
      run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
      if (f == 15) chk("R10 held before 16 frames", {26'd0, up[7:2]}, 32'h2D);
      if (f == 16) chk("R10 reported after 16 frames", {26'd0, up[7:2]}, 32'h30);
    end

    // R11: monitor byte repetition
    upd_int = 4'd0;
    mon_tx = 8'h3C;
    run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
    chk("R11 new monitor byte taken", {24'd0, up[15:8]}, 32'h3C);
    mon_tx = 8'h5A;
    run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
    chk("R11 monitor byte repeated", {24'd0, up[15:8]}, 32'h3C);
    run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
    chk("R11 next monitor byte", {24'd0, up[15:8]}, 32'h5A);
    mon_tx = 8'h77;
    run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
    chk("R11 second send of byte", {24'd0, up[15:8]}, 32'h5A);
    run_frame(1'b0, 3'd0, 32'h0, up, en_bad, strobes);
    chk("R11 third byte after two sends", {24'd0, up[15:8]}, 32'h77);

    // R4: other channels' data leaves outputs unchanged at high rate
    run_frame(1'b1, 3'd6, 32'h0F0F0F0F, up, en_bad, strobes);
    chk("R4 slot six fields", {v1_rx, v2_rx, mon_rx, cmd_rx, mr_rx, mx_rx}, 32'h0F0F0F0F);
    chk("R7 slot six enable window", 32'(en_bad), 32'd0);

    finish_run();
  end
endmodule